// File: doc/BRIEF.md
# Byte-Programmed GPIO Bank with Polarity Control and Edge Capture

The block is a bank of up to eight general-purpose pins that software sets up through a byte-wide register port. Each pin can be an input or an output. The bank has these per-pin controls:

- a polarity bit, which flips the pin's value on both the read path and the drive path;
- a drive-style bit, which selects push-pull or open drain;
- a reserve bit, which takes the pin away from GPIO use.

Inputs pass through a two-stage synchronizer. Any change of a pin's synchronized, polarity-adjusted value is recorded in a sticky capture register, and reading that register clears it.

The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read is launched by `rd_en`, and its byte appears on `rdata` in the following cycle. `rdata` is zero in every cycle that does not follow a read. The parameter `NPINS` sets the pin count from 1 to 8. A single-pin bank uses bit 0 only, and its unused register bits read as 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction bits are all 1 and the polarity, capture, output data, drive-style and reserve registers are all 0. `pin_oe` and `pin_o` are 0.
- R2: The register offsets are: 0 direction, 1 data, 2 polarity, 3 capture, 4 drive style, 5 reserve. Direction, polarity, drive style and reserve read back the last value written. A write to offset 3 has no effect.
- R3: A direction bit of 1 makes the pin an input, and `pin_oe` stays 0 for it. A direction bit of 0 makes the pin an output.
- R4: For an output pin whose drive-style bit is 0 (push-pull), `pin_oe` is 1 and `pin_o` equals the data bit XOR the polarity bit.
- R5: For an output pin whose drive-style bit is 1 (open drain), a level of 0 (data XOR polarity) gives `pin_oe`=1 and `pin_o`=0. A level of 1 gives `pin_oe`=0. Whenever `pin_oe` is 0, `pin_o` is 0.
- R6: A read of offset 1 returns, for input pins, the synchronized `pin_i` XOR polarity, and for output pins, the stored data bit. A change on `pin_i` is visible in a read launched two cycles after the change.
- R7: Any change of a pin's synchronized, polarity-adjusted value sets its capture bit. The bit stays set until offset 3 is read. That read returns the bits and clears them, except for a change detected in the same cycle as the read, which stays set.
- R8: A pin whose reserve bit is 1 never asserts `pin_oe`, and it reads as 0 in the data and capture registers.
- R9: `rdata` carries the read byte in the cycle after `rd_en`. It is 0 after a cycle with no read, and it is 0 after a read of an offset above 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| pin_i | input | NPINS | Raw pin input values |
| pin_o | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables |

## Verification
The assertions assume the following about the inputs:

- `wr_en` and `rd_en` are never high in the same cycle;
- `addr` is valid whenever either strobe is high;
- the reserve register is not rewritten in the cycle in which a capture bit's stickiness is judged.

The stimulus drives every input at the falling clock edge and issues one register operation per cycle, which keeps these conditions true. Pin changes are separated by enough cycles for the synchronizer, except in the one test that lines up an edge with a capture read on purpose.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR  = 3'd0,
    OFS_DATA = 3'd1,
    OFS_POL  = 3'd2,
    OFS_CAP  = 3'd3,
    OFS_MODE = 3'd4,
    OFS_RSV  = 3'd5
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] usable,
  input  logic         clr,
  output logic [W-1:0] edge_v,
  output logic [W-1:0] cap
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cap_q;

  assign edge_v = (level ^ prev_q) & usable;
  assign cap    = cap_q & usable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= level;
      if (clr) cap_q <= edge_v;
      else     cap_q <= (cap_q | edge_v) & usable;
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] level,
  input  logic [W-1:0] usable,
  output logic [W-1:0] oe,
  output logic [W-1:0] o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drive;
    // Push-pull drives whenever output; open drain only pulls low.
    assign drive = usable[i] & ~dir[i] & (~mode[i] | ~level[i]);
    assign oe[i] = drive;
    assign o[i]  = drive & level[i];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [NPINS-1:0]    pin_i,
  output logic [NPINS-1:0]    pin_o,
  output logic [NPINS-1:0]    pin_oe
);
  localparam int unsigned W = NPINS;

  logic [W-1:0] dir_q, data_q, pol_q, mode_q, rsv_q;
  logic [W-1:0] sync_v, level_in, usable, edge_v, cap_v, rd_view;
  logic         cap_rd;
  logic [BYTE_W-1:0] rd_mux;

  assign usable   = ~rsv_q;
  assign level_in = sync_v ^ pol_q;
  assign cap_rd   = rd_en && (addr == OFS_CAP);
  assign rd_view  = ((dir_q & level_in) | (~dir_q & data_q)) & usable;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_v)
  );

  gpio_edge_status #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(level_in), .usable(usable),
    .clr(cap_rd), .edge_v(edge_v), .cap(cap_v)
  );

  gpio_pad_drive #(.W(W)) u_pad (
    .dir(dir_q), .mode(mode_q), .level(data_q ^ pol_q), .usable(usable),
    .oe(pin_oe), .o(pin_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      data_q <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      rsv_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DIR:  dir_q  <= wdata[W-1:0];
        OFS_DATA: data_q <= wdata[W-1:0];
        OFS_POL:  pol_q  <= wdata[W-1:0];
        OFS_MODE: mode_q <= wdata[W-1:0];
        OFS_RSV:  rsv_q  <= wdata[W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_DIR:  rd_mux[W-1:0] = dir_q;
      OFS_DATA: rd_mux[W-1:0] = rd_view;
      OFS_POL:  rd_mux[W-1:0] = pol_q;
      OFS_CAP:  rd_mux[W-1:0] = cap_v;
      OFS_MODE: rd_mux[W-1:0] = mode_q;
      OFS_RSV:  rd_mux[W-1:0] = rsv_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [7:0]   rdata,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] mode_q,
  input logic [W-1:0] rsv_q,
  input logic [W-1:0] edge_v,
  input logic [W-1:0] cap_v
);
  // R3
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);
  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & rsv_q) == '0);
  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_o & mode_q) == '0);
  // R5
  released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_o & ~pin_oe) == '0);
  // R7
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd3) |=> ((cap_v & ~$past(edge_v)) == '0));
  // R7
  cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_en && addr == 3'd3) && !(wr_en && addr == 3'd5)) |=>
      (($past(cap_v) & ~cap_v) == '0));
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 8'h00));
  // R9
  rdata_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > 3'd5) |=> (rdata == 8'h00));
endmodule

bind gpio_bank gpio_bank_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .pin_o(pin_o), .pin_oe(pin_oe), .dir_q(dir_q),
  .mode_q(mode_q), .rsv_q(rsv_q), .edge_v(edge_v), .cap_v(cap_v)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_o, pin_oe;
  int checks = 0, failures = 0;
  logic [7:0] r;

  always #5 clk = ~clk;

  gpio_bank #(.NPINS(8)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // fields: dir, pol, mode, data, pin_i, exp oe, exp pin_o, exp data read
  localparam logic [63:0] VEC [5] = '{
    64'hFF_00_00_00_A5_00_00_A5,
    64'h00_00_00_3C_00_FF_3C_3C,
    64'h0F_F0_00_00_5A_F0_F0_0A,
    64'h00_00_FF_C3_00_3C_00_C3,
    64'hF0_0F_0F_05_33_05_00_35
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 pin_o", pin_o, 8'h00);
    rd(3'd0, r); chk("R1 dir", r, 8'hFF);
    rd(3'd2, r); chk("R1 pol", r, 8'h00);
    rd(3'd3, r); chk("R1 cap", r, 8'h00);
    rd(3'd4, r); chk("R1 mode", r, 8'h00);
    rd(3'd5, r); chk("R1 rsv", r, 8'h00);
    rd(3'd1, r); chk("R1 data", r, 8'h00);
    @(negedge clk); chk("R9 idle rdata", rdata, 8'h00);

    // vector table: R3 R4 R5 R6
    for (int k = 0; k < 5; k++) begin
      wr(3'd2, VEC[k][55:48]);
      wr(3'd4, VEC[k][47:40]);
      wr(3'd1, VEC[k][39:32]);
      wr(3'd0, VEC[k][63:56]);
      @(negedge clk); pin_i = VEC[k][31:24];
      repeat (3) @(negedge clk);
      chk("R3/R4/R5 oe", pin_oe, VEC[k][23:16]);
      chk("R4/R5 pin_o", pin_o, VEC[k][15:8]);
      rd(3'd1, r); chk("R6 data read", r, VEC[k][7:0]);
      rd(3'd3, r);
    end

    // R2 readback, capture write ignored, R9 unmapped
    wr(3'd0, 8'h5A); rd(3'd0, r); chk("R2 dir readback", r, 8'h5A);
    wr(3'd2, 8'h00); wr(3'd0, 8'hFF); pin_i = 8'h00;
    repeat (4) @(negedge clk);
    rd(3'd3, r); rd(3'd3, r); chk("R7 cap cleared", r, 8'h00);
    wr(3'd3, 8'hFF); rd(3'd3, r); chk("R2 cap write ignored", r, 8'h00);
    rd(3'd7, r); chk("R9 unmapped", r, 8'h00);

    // R7 capture and clear
    @(negedge clk); pin_i = 8'h01;
    repeat (3) @(negedge clk);
    rd(3'd3, r); chk("R7 cap set", r, 8'h01);
    rd(3'd3, r); chk("R7 cap clear on read", r, 8'h00);
    // R7 edge coincident with read stays set
    @(negedge clk); pin_i = 8'h00;
    @(negedge clk);
    rd(3'd3, r); chk("R7 coincident read", r, 8'h00);
    rd(3'd3, r); chk("R7 coincident kept", r, 8'h01);

    // R8 reserved pin
    wr(3'd5, 8'h01); wr(3'd4, 8'h00); wr(3'd2, 8'h00);
    wr(3'd1, 8'hFF); wr(3'd0, 8'h00);
    @(negedge clk);
    chk("R8 oe", pin_oe, 8'hFE);
    chk("R8 pin_o", pin_o, 8'hFE);
    rd(3'd1, r); chk("R8 data read", r, 8'hFE);
    rd(3'd3, r);
    wr(3'd0, 8'hFF);
    @(negedge clk); pin_i = 8'h01;
    repeat (3) @(negedge clk);
    rd(3'd3, r); chk("R8 cap masked", r, 8'h00);
    rd(3'd1, r); chk("R8 input read", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule